// File: doc/BRIEF.md
# Memory-Mapped Disk Task-File Bridge

This block sits between a processor-side memory-mapped bus and the register interface of an ATA/IDE disk device. The bus issues byte, halfword or word accesses. Device registers sit one per 16-byte slot, so the register index is taken from address bits 11:4 and every other address bit is ignored. From the index and the access size, the bridge picks one target. Byte accesses can reach the seven task-file registers or the device control/status pair, which answers at two aliased indices. Halfword and word accesses can reach only the data port, at index 0.

The bus is big-endian and the disk data path is little-endian, so the bridge reverses the byte order of data-port traffic in both directions. A read from an unmapped location returns all-ones at the width of the access. A write to an unmapped location raises no strobe. The device answers in the same cycle as a strobe. The bridge registers the read result and presents it one cycle after the request, with one access in flight at a time. A status read raises its own strobe, so that the device can clear a pending interrupt.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is bus_addr[11:4]. Address bits above 11 and below 4 have no effect on decoding.
- R2: A byte access (bus_size=0) with index 1 to 7 raises tf_rd (read) or tf_wr (write) with tf_sel equal to index[2:0]. On a write, tf_wdata is bus_wdata[7:0]. On a read, the result is tf_rdata zero-extended to 32 bits.
- R3: A byte access at index 8 or index 22 raises ctl_wr on a write, with ctl_wdata = bus_wdata[7:0]. On a read it raises stat_rd and returns stat_rdata zero-extended to 32 bits.
- R4: A byte access at any other index, including 0, raises no strobe. A read there returns 32'h000000FF.
- R5: A halfword access (bus_size=1) at index 0 raises dp_rd or dp_wr with dp_wide=0. The write data presented is {16'h0, bus_wdata[7:0], bus_wdata[15:8]}. The read result is {16'h0, dp_rdata[7:0], dp_rdata[15:8]}.
- R6: A word access (bus_size=2) at index 0 raises dp_rd or dp_wr with dp_wide=1. The four bytes are reversed in both directions, so bus byte 3 (bits 31:24) maps to device byte 0.
- R7: A halfword or word access at a non-zero index raises no strobe. The read returns 32'h0000FFFF for a halfword and 32'hFFFFFFFF for a word. The reserved size (bus_size=3) behaves the same at every index and returns 32'hFFFFFFFF.
- R8: bus_rvalid is high for exactly the one cycle after each read request, with bus_rdata holding the result. A write never raises bus_rvalid. At most one device strobe is active in any cycle.
- R9: After reset, bus_rvalid and bus_rdata are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read result |
| bus_rvalid | output | 1 | Read result valid |
| tf_sel | output | 3 | Task-file register number |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_wdata | output | 8 | Task-file write byte |
| tf_rdata | input | 8 | Task-file read byte |
| ctl_wr | output | 1 | Device control write strobe |
| ctl_wdata | output | 8 | Device control byte |
| stat_rd | output | 1 | Status read strobe (acknowledges interrupt) |
| stat_rdata | input | 8 | Status byte |
| dp_rd | output | 1 | Data port read strobe |
| dp_wr | output | 1 | Data port write strobe |
| dp_wide | output | 1 | 1 = 32-bit data port transfer, 0 = 16-bit |
| dp_wdata | output | 32 | Byte-swapped data port write data |
| dp_rdata | input | 32 | Little-endian data port read data |

## Verification
The bench targets the second control alias at index 22. A decoder that matches only index 8 returns 0xFF there and never strobes the status register. It also probes high and low address bits that must be masked out: a decoder that uses them lands on the wrong register or reports unmapped. Byte accesses at index 0 and halfword or word accesses at non-zero indices must not reach the data port. A design that keys on the index alone or on the size alone would raise a data-port strobe there and return device data instead of the sized all-ones pattern. Known asymmetric patterns check the swapped halfword and word data in both directions, so a missing or partial byte reversal shows up as a wrong lane order.

// File: rtl/mab_pkg.sv
package mab_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_TF   = 2'd1,
      TGT_CTL  = 2'd2,
      TGT_DATA = 2'd3
   } target_e;

endpackage

// File: rtl/mab_decode.sv
module mab_decode
   import mab_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_LO    = 4,
   parameter int IDX_HI    = 11,
   parameter int TF_FIRST  = 1,
   parameter int TF_LAST   = 7,
   parameter int CTL_IDX_A = 8,
   parameter int CTL_IDX_B = 22,
   parameter int DATA_IDX  = 0,
   localparam int IDX_W    = IDX_HI - IDX_LO + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic [IDX_W-1:0]  index,
   output target_e           target
);

   assign index = addr[IDX_HI:IDX_LO];

   logic is_tf, is_ctl, is_data;

   always_comb begin
      is_tf   = (int'(index) >= TF_FIRST) && (int'(index) <= TF_LAST);
      is_ctl  = (int'(index) == CTL_IDX_A) || (int'(index) == CTL_IDX_B);
      is_data = (int'(index) == DATA_IDX);
   end

   always_comb begin
      target = TGT_NONE;
      unique case (acc_size_e'(size))
         SZ_BYTE: begin
            if (is_tf)       target = TGT_TF;
            else if (is_ctl) target = TGT_CTL;
         end
         SZ_HALF, SZ_WORD: begin
            if (is_data) target = TGT_DATA;
         end
         default: target = TGT_NONE;
      endcase
   end

endmodule

// File: rtl/mab_swap.sv
module mab_swap #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int W     = LANES * LANE_W
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (LANES < 1) begin : g_bad
         $error("mab_swap: LANES must be at least 1");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign dout[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/mab_rdreg.sv
module mab_rdreg
   import mab_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int REG_W  = 8,
   localparam int HALF_W = BUS_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  target_e          target,
   input  logic [1:0]       size,
   input  logic [REG_W-1:0] tf_val,
   input  logic [REG_W-1:0] stat_val,
   input  logic [HALF_W-1:0] half_sw,
   input  logic [BUS_W-1:0] word_sw,
   output logic [BUS_W-1:0] rdata,
   output logic             rvalid
);

   logic [BUS_W-1:0] nxt;

   always_comb begin
      nxt = '0;
      unique case (target)
         TGT_TF:   nxt = BUS_W'(tf_val);
         TGT_CTL:  nxt = BUS_W'(stat_val);
         TGT_DATA: nxt = (acc_size_e'(size) == SZ_HALF) ? BUS_W'(half_sw) : word_sw;
         default: begin
            unique case (acc_size_e'(size))
               SZ_BYTE: nxt = BUS_W'({REG_W{1'b1}});
               SZ_HALF: nxt = BUS_W'({HALF_W{1'b1}});
               default: nxt = {BUS_W{1'b1}};
            endcase
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_req;
         if (rd_req) rdata <= nxt;
      end
   end

endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
   import mab_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BUS_W     = 32,
   parameter int REG_W     = 8,
   parameter int IDX_LO    = 4,
   parameter int IDX_HI    = 11,
   parameter int TF_FIRST  = 1,
   parameter int TF_LAST   = 7,
   parameter int CTL_IDX_A = 8,
   parameter int CTL_IDX_B = 22,
   parameter int SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_rvalid,
   output logic [SEL_W-1:0]  tf_sel,
   output logic              tf_rd,
   output logic              tf_wr,
   output logic [REG_W-1:0]  tf_wdata,
   input  logic [REG_W-1:0]  tf_rdata,
   output logic              ctl_wr,
   output logic [REG_W-1:0]  ctl_wdata,
   output logic              stat_rd,
   input  logic [REG_W-1:0]  stat_rdata,
   output logic              dp_rd,
   output logic              dp_wr,
   output logic              dp_wide,
   output logic [BUS_W-1:0]  dp_wdata,
   input  logic [BUS_W-1:0]  dp_rdata
);

   localparam int IDX_W      = IDX_HI - IDX_LO + 1;
   localparam int LANES      = BUS_W / REG_W;
   localparam int HALF_LANES = LANES / 2;
   localparam int HALF_W     = BUS_W / 2;

   generate
      if (BUS_W != 4 * REG_W) begin : g_chk_bus
         $error("mmio_ata_bridge: bus must be four register lanes wide");
      end
      if ((1 << IDX_W) <= CTL_IDX_B || (1 << IDX_W) <= CTL_IDX_A) begin : g_chk_idx
         $error("mmio_ata_bridge: index field too narrow for control aliases");
      end
      if ((1 << SEL_W) <= TF_LAST) begin : g_chk_sel
         $error("mmio_ata_bridge: select width too narrow");
      end
      if (IDX_HI >= ADDR_W) begin : g_chk_addr
         $error("mmio_ata_bridge: index above address width");
      end
   endgenerate

   logic [IDX_W-1:0] index;
   target_e          target;

   mab_decode #(
      .ADDR_W   (ADDR_W),
      .IDX_LO   (IDX_LO),
      .IDX_HI   (IDX_HI),
      .TF_FIRST (TF_FIRST),
      .TF_LAST  (TF_LAST),
      .CTL_IDX_A(CTL_IDX_A),
      .CTL_IDX_B(CTL_IDX_B),
      .DATA_IDX (0)
   ) u_decode (
      .addr  (bus_addr),
      .size  (bus_size),
      .index (index),
      .target(target)
   );

   logic [HALF_W-1:0] wr_half_sw, rd_half_sw;
   logic [BUS_W-1:0]  wr_word_sw, rd_word_sw;

   mab_swap #(.LANES(HALF_LANES), .LANE_W(REG_W)) u_wr_half (
      .din (bus_wdata[HALF_W-1:0]),
      .dout(wr_half_sw)
   );
   mab_swap #(.LANES(LANES), .LANE_W(REG_W)) u_wr_word (
      .din (bus_wdata),
      .dout(wr_word_sw)
   );
   mab_swap #(.LANES(HALF_LANES), .LANE_W(REG_W)) u_rd_half (
      .din (dp_rdata[HALF_W-1:0]),
      .dout(rd_half_sw)
   );
   mab_swap #(.LANES(LANES), .LANE_W(REG_W)) u_rd_word (
      .din (dp_rdata),
      .dout(rd_word_sw)
   );

   logic rd_go, wr_go;

   always_comb begin
      rd_go = bus_req && !bus_we;
      wr_go = bus_req &&  bus_we;
   end

   always_comb begin
      tf_sel    = index[SEL_W-1:0];
      tf_wdata  = bus_wdata[REG_W-1:0];
      ctl_wdata = bus_wdata[REG_W-1:0];
      tf_rd     = rd_go && (target == TGT_TF);
      tf_wr     = wr_go && (target == TGT_TF);
      stat_rd   = rd_go && (target == TGT_CTL);
      ctl_wr    = wr_go && (target == TGT_CTL);
      dp_rd     = rd_go && (target == TGT_DATA);
      dp_wr     = wr_go && (target == TGT_DATA);
      dp_wide   = (acc_size_e'(bus_size) == SZ_WORD);
      dp_wdata  = dp_wide ? wr_word_sw : BUS_W'(wr_half_sw);
   end

   mab_rdreg #(
      .BUS_W(BUS_W),
      .REG_W(REG_W)
   ) u_rdreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (rd_go),
      .target  (target),
      .size    (bus_size),
      .tf_val  (tf_rdata),
      .stat_val(stat_rdata),
      .half_sw (rd_half_sw),
      .word_sw (rd_word_sw),
      .rdata   (bus_rdata),
      .rvalid  (bus_rvalid)
   );

endmodule

// File: rtl/mab_bridge_chk.sv
module mab_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_req,
   input logic        bus_we,
   input logic [1:0]  bus_size,
   input logic [31:0] bus_addr,
   input logic [31:0] bus_rdata,
   input logic        bus_rvalid,
   input logic [2:0]  tf_sel,
   input logic        tf_rd,
   input logic        tf_wr,
   input logic        ctl_wr,
   input logic        stat_rd,
   input logic [7:0]  stat_rdata,
   input logic        dp_rd,
   input logic        dp_wr,
   input logic        dp_wide,
   input logic [31:0] dp_rdata
);

   logic [7:0] idx;
   logic [5:0] strobes;
   assign idx     = bus_addr[11:4];
   assign strobes = {tf_rd, tf_wr, ctl_wr, stat_rd, dp_rd, dp_wr};

   // R2
   a_r2_tf_route: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_size == 2'd0 && idx >= 8'd1 && idx <= 8'd7)
      |-> (tf_rd && tf_sel == idx[2:0]));

   // R3
   a_r3_stat_return: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (bus_rvalid && bus_rdata == {24'h0, $past(stat_rdata)}));

   // R4
   a_r4_unmapped_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size == 2'd0 && (idx == 8'd0 || idx > 8'd7)
       && idx != 8'd8 && idx != 8'd22) |-> (strobes == 6'b0));

   // R6
   a_r6_word_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd && dp_wide) |=> (bus_rdata == {$past(dp_rdata[7:0]), $past(dp_rdata[15:8]),
                                           $past(dp_rdata[23:16]), $past(dp_rdata[31:24])}));

   // R7
   a_r7_no_dp_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size != 2'd0 && idx != 8'd0) |-> (!dp_rd && !dp_wr));

   // R8
   a_r8_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);
   a_r8_rvalid_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);
   a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));

endmodule

bind mmio_ata_bridge mab_bridge_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_size  (bus_size),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_rvalid(bus_rvalid),
   .tf_sel    (tf_sel),
   .tf_rd     (tf_rd),
   .tf_wr     (tf_wr),
   .ctl_wr    (ctl_wr),
   .stat_rd   (stat_rd),
   .stat_rdata(stat_rdata),
   .dp_rd     (dp_rd),
   .dp_wr     (dp_wr),
   .dp_wide   (dp_wide),
   .dp_rdata  (dp_rdata)
);

// File: tb/mmio_ata_bridge_bench.sv
module mmio_ata_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [2:0]  tf_sel;
   logic        tf_rd, tf_wr, ctl_wr, stat_rd, dp_rd, dp_wr, dp_wide;
   logic [7:0]  tf_wdata, ctl_wdata, tf_rdata, stat_rdata;
   logic [31:0] dp_wdata, dp_rdata;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   // simple device model
   assign tf_rdata   = 8'hA0 | {5'h0, tf_sel};
   assign stat_rdata = 8'h50;
   assign dp_rdata   = 32'h11223344;

   mmio_ata_bridge u_mmio_ata_bridge (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tf_sel(tf_sel),
      .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
      .stat_rdata(stat_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wide(dp_wide),
      .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // fields: we | size | addr[15:0] | wdata | strobes{tf_rd,tf_wr,ctl_wr,stat_rd,dp_rd,dp_wr} | rdata
   localparam int NV = 19;
   localparam logic [88:0] VEC [NV] = '{
      {1'b0, 2'd0, 16'h0010, 32'h0,        6'b100000, 32'h000000A1}, // R2
      {1'b0, 2'd0, 16'h0070, 32'h0,        6'b100000, 32'h000000A7}, // R2
      {1'b0, 2'd0, 16'h0080, 32'h0,        6'b000100, 32'h00000050}, // R3
      {1'b0, 2'd0, 16'h0160, 32'h0,        6'b000100, 32'h00000050}, // R3 alias
      {1'b0, 2'd0, 16'h0090, 32'h0,        6'b000000, 32'h000000FF}, // R4
      {1'b0, 2'd0, 16'h0000, 32'h0,        6'b000000, 32'h000000FF}, // R4 byte at 0
      {1'b0, 2'd0, 16'h503B, 32'h0,        6'b100000, 32'h000000A3}, // R1 masking
      {1'b0, 2'd1, 16'h0000, 32'h0,        6'b000010, 32'h00004433}, // R5
      {1'b0, 2'd2, 16'h000C, 32'h0,        6'b000010, 32'h44332211}, // R6
      {1'b0, 2'd1, 16'h0010, 32'h0,        6'b000000, 32'h0000FFFF}, // R7
      {1'b0, 2'd2, 16'h0020, 32'h0,        6'b000000, 32'hFFFFFFFF}, // R7
      {1'b1, 2'd0, 16'h0050, 32'h0000007E, 6'b010000, 32'h0},        // R2 write
      {1'b1, 2'd0, 16'h0080, 32'h00000012, 6'b001000, 32'h0},        // R3 write
      {1'b1, 2'd0, 16'h0160, 32'h00000034, 6'b001000, 32'h0},        // R3 alias write
      {1'b1, 2'd0, 16'h00A0, 32'h00000055, 6'b000000, 32'h0},        // R4 write ignored
      {1'b1, 2'd1, 16'h0000, 32'h0000BEEF, 6'b000001, 32'h0},        // R5 write
      {1'b1, 2'd2, 16'h0000, 32'h01020304, 6'b000001, 32'h0},        // R6 write
      {1'b1, 2'd2, 16'h0030, 32'hCAFEF00D, 6'b000000, 32'h0},        // R7 write ignored
      {1'b0, 2'd3, 16'h0000, 32'h0,        6'b000000, 32'hFFFFFFFF}  // R7 reserved size
   };

   function automatic logic [31:0] rev_bytes(input logic [31:0] v, input int n);
      logic [31:0] r = '0;
      for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
      return r;
   endfunction

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 rvalid", {31'h0, bus_rvalid}, 32'h0);
      check("R9 rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 strobes idle",
            {26'h0, tf_rd, tf_wr, ctl_wr, stat_rd, dp_rd, dp_wr}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         logic        we;
         logic [1:0]  sz;
         logic [31:0] wd, exp_dp;
         we = VEC[v][88];
         sz = VEC[v][87:86];
         wd = VEC[v][69:38];
         bus_req   = 1'b1;
         bus_we    = we;
         bus_size  = sz;
         bus_addr  = {16'hF000, VEC[v][85:70]};
         bus_wdata = wd;
         #2;
         check($sformatf("R8 strobes vec%0d", v),
               {26'h0, tf_rd, tf_wr, ctl_wr, stat_rd, dp_rd, dp_wr},
               {26'h0, VEC[v][37:32]});
         if (tf_rd || tf_wr)
            check($sformatf("R2 tf_sel vec%0d", v), {29'h0, tf_sel}, {29'h0, VEC[v][76:74]});
         if (tf_wr) check("R2 tf_wdata", {24'h0, tf_wdata}, {24'h0, wd[7:0]});
         if (ctl_wr) check("R3 ctl_wdata", {24'h0, ctl_wdata}, {24'h0, wd[7:0]});
         if (dp_wr) begin
            exp_dp = (sz == 2'd2) ? rev_bytes(wd, 4) : rev_bytes(wd & 32'hFFFF, 2);
            check($sformatf("R5/R6 dp_wdata vec%0d", v), dp_wdata, exp_dp);
            check("R5/R6 dp_wide", {31'h0, dp_wide}, {31'h0, sz == 2'd2});
         end
         @(negedge clk);
         bus_req = 1'b0;
         check($sformatf("R8 rvalid vec%0d", v), {31'h0, bus_rvalid}, {31'h0, !we});
         if (!we) check($sformatf("R1-7 rdata vec%0d", v), bus_rdata, VEC[v][31:0]);
         @(negedge clk);
         check($sformatf("R8 rvalid drop vec%0d", v), {31'h0, bus_rvalid}, 32'h0);
      end

      // R8 back-to-back reads keep rvalid high with fresh data each cycle
      bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'd0; bus_addr = 32'h20;
      @(negedge clk);
      check("R8 b2b first", bus_rdata, 32'h000000A2);
      bus_addr = 32'h160;
      @(negedge clk);
      check("R8 b2b rvalid", {31'h0, bus_rvalid}, 32'h1);
      check("R3 b2b alias", bus_rdata, 32'h00000050);
      bus_req = 1'b0;
      @(negedge clk);
      check("R8 b2b end", {31'h0, bus_rvalid}, 32'h0);

      // R9 reset mid-run clears the read register
      rst_n = 1'b0;
      #2;
      check("R9 reset rdata", bus_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule